// File: doc/BRIEF.md
# Constant-Operation Byte ALU

A purely combinational arithmetic/logic unit that maps two unsigned operand bytes and a two-bit operation code onto one result byte. Its four operations all use fixed constants. It tests whether the first operand is exactly four times the second. It tests whether the first operand is a multiple of sixteen. It scales the first operand by nine. It picks the smaller of the two operands. The two tests produce a boolean word whose only possible non-zero bit is bit 0. Constant scaling is done with shifts and one adder, with no general multiplier or divider.

A control decoder turns the operation code into a small set of select strobes. A datapath computes all four candidate results in parallel and merges them through an AND-OR select. The result follows the inputs with no clock and no state.

Top module: `const_alu`

## Requirements
- R1: With opCode 2'b00, result is 8'h01 when opA equals four times opB, computed without truncation (so any opB of 64 or more gives 8'h00), and 8'h00 otherwise.
- R2: With opCode 2'b01, result is 8'h01 when the low four bits of opA are all zero and 8'h00 otherwise; opB has no effect on result.
- R3: With opCode 2'b10, result equals opA multiplied by nine, keeping only the low 8 bits; opB has no effect on result.
- R4: With opCode 2'b11, result is the unsigned minimum of opA and opB; when the two are equal the value returned is that common value.
- R5: For opCodes 2'b00 and 2'b01, result bits 7 down to 1 are always zero; bit 0 carries the outcome of the test.
- R6: The block holds no state: result reflects the present inputs within the same clock period in which they are applied, whatever the earlier inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First unsigned operand |
| opB | input | 8 | Second unsigned operand |
| opCode | input | 2 | Operation select: 00 quadruple test, 01 multiple-of-16 test, 10 times nine, 11 minimum |
| result | output | 8 | Result byte |

## Verification
The bench builds the block at its default byte width, with a shift of two for the quadruple test, four low bits for the multiple-of-sixteen test and a shift of three for the times-nine term. At this width the whole truncation region is easy to reach. That region includes opB values at and above 64, where a narrow comparison would wrap. It also includes opA values above 28, where times nine overflows. Directed vectors cover 0, 255, 16, 64, equal operands and sweeps of the ignored operand. Randomised vectors are compared against an arithmetic model that uses integer multiply and modulo.

// File: rtl/const_alu_pkg.sv
`timescale 1ns/1ps
package const_alu_pkg;

  typedef enum logic [1:0] {
    OP_QUAD  = 2'b00,
    OP_MOD16 = 2'b01,
    OP_MUL9  = 2'b10,
    OP_MIN   = 2'b11
  } aluOp_e;

  // one strobe per candidate result, driven by the control decoder
  typedef struct packed {
    logic selQuad;
    logic selMod;
    logic selMul;
    logic selMin;
  } aluSel_t;

endpackage

// File: rtl/const_alu_ctrl.sv
`timescale 1ns/1ps
module const_alu_ctrl
  import const_alu_pkg::*;
(
  input  logic [1:0] opCode,
  output aluSel_t    sel
);

  aluOp_e opDec;

  always_comb begin
    opDec = aluOp_e'(opCode);
    sel   = '0;
    unique case (opDec)
      OP_QUAD:  sel.selQuad = 1'b1;
      OP_MOD16: sel.selMod  = 1'b1;
      OP_MUL9:  sel.selMul  = 1'b1;
      OP_MIN:   sel.selMin  = 1'b1;
      default:  sel         = '0;
    endcase
  end

endmodule

// File: rtl/const_alu_dp.sv
`timescale 1ns/1ps
module const_alu_dp
  import const_alu_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int QUAD_SH  = 2,  // four times = shift by two
  parameter int MOD_BITS = 4,  // multiple of sixteen = low four bits zero
  parameter int MUL_SH   = 3   // nine times = (x << 3) + x
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluSel_t          sel,
  output logic [WIDTH-1:0] result
);

  localparam int EXT_W = WIDTH + QUAD_SH;

  logic [EXT_W-1:0] aExt;
  logic [EXT_W-1:0] bScaled;
  logic             quadHit;
  logic             modHit;
  logic [WIDTH-1:0] aShifted;
  logic [WIDTH-1:0] mulRes;
  logic [WIDTH-1:0] minRes;
  logic [WIDTH-1:0] quadWord;
  logic [WIDTH-1:0] modWord;

  // quadruple test at full width so large opB cannot wrap into a match
  assign aExt    = {{QUAD_SH{1'b0}}, opA};
  assign bScaled = {opB, {QUAD_SH{1'b0}}};
  assign quadHit = (aExt == bScaled);

  // multiple of 2**MOD_BITS
  assign modHit = ~|opA[MOD_BITS-1:0];

  // constant multiply via shift and add, truncated to WIDTH
  assign aShifted = opA << MUL_SH;
  assign mulRes   = aShifted + opA;

  // unsigned minimum, ties resolve to opA
  assign minRes = (opB < opA) ? opB : opA;

  // predicates become zero-extended boolean words
  assign quadWord = {{(WIDTH-1){1'b0}}, quadHit};
  assign modWord  = {{(WIDTH-1){1'b0}}, modHit};

  // AND-OR merge, one lane per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign result[i] = (sel.selQuad & quadWord[i]) |
                       (sel.selMod  & modWord[i])  |
                       (sel.selMul  & mulRes[i])   |
                       (sel.selMin  & minRes[i]);
  end

endmodule

// File: rtl/const_alu.sv
`timescale 1ns/1ps
module const_alu
  import const_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opCode,
  output logic [WIDTH-1:0] result
);

  aluSel_t selBus;

  const_alu_ctrl ctrl_i (
    .opCode (opCode),
    .sel    (selBus)
  );

  const_alu_dp #(
    .WIDTH    (WIDTH),
    .QUAD_SH  (2),
    .MOD_BITS (4),
    .MUL_SH   (3)
  ) dp_i (
    .opA    (opA),
    .opB    (opB),
    .sel    (selBus),
    .result (result)
  );

endmodule

// File: rtl/const_alu_chk.sv
`timescale 1ns/1ps
module const_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [1:0]       opCode,
  input logic [WIDTH-1:0] result
);

  always_comb begin
    if (opCode == 2'b00) begin
      p_quad_r1: assert (result == WIDTH'(int'(opA) == 4 * int'(opB)))
        else $error("quadruple test mismatch");
    end
    if (opCode == 2'b01) begin
      p_mod16_r2: assert (result == WIDTH'((int'(opA) % 16) == 0))
        else $error("multiple-of-16 test mismatch");
    end
    if (opCode == 2'b10) begin
      p_mul9_r3: assert (result == WIDTH'(int'(opA) * 9))
        else $error("times nine mismatch");
    end
    if (opCode == 2'b11) begin
      p_min_r4: assert (result <= opA && result <= opB &&
                        (result == opA || result == opB))
        else $error("minimum mismatch");
    end
    if (opCode[1] == 1'b0) begin
      p_pred_word_r5: assert (result[WIDTH-1:1] == '0)
        else $error("predicate word has upper bits set");
    end
  end

endmodule

bind const_alu const_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .opA    (opA),
  .opB    (opB),
  .opCode (opCode),
  .result (result)
);

// File: tb/const_alu_tb_top.sv
`timescale 1ns/1ps
module const_alu_tb_top;

  logic       clk = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [1:0] opCode = '0;
  logic [7:0] result;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  const_alu dut_i (
    .opA    (opA),
    .opB    (opB),
    .opCode (opCode),
    .result (result)
  );

  // independent arithmetic model
  function automatic logic [7:0] model(input logic [1:0] op,
                                       input logic [7:0] a,
                                       input logic [7:0] b);
    int ai = int'(a);
    int bi = int'(b);
    case (op)
      2'b00:   return (ai == bi * 4) ? 8'd1 : 8'd0;
      2'b01:   return (ai % 16 == 0) ? 8'd1 : 8'd0;
      2'b10:   return 8'((ai * 9) % 256);
      default: return (ai <= bi) ? a : b;
    endcase
  endfunction

  // drive at falling edge, sample 5 ns later, away from the rising edge
  task automatic apply(input string req, input logic [1:0] op,
                       input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] exp);
    @(negedge clk);
    opCode = op;
    opA    = a;
    opB    = b;
    #5;
    nVec++;
    if (result !== exp) begin
      nBad++;
      $display("FAIL %s op=%b a=%0d b=%0d actual=%0d expected=%0d",
               req, op, a, b, result, exp);
    end
  endtask

  task automatic t_initial();
    // all-zero inputs: quadruple test 0 == 4*0 is true (R1)
    apply("R1", 2'b00, 8'd0, 8'd0, 8'd1);
  endtask

  task automatic t_quad();
    apply("R1", 2'b00, 8'd64,  8'd16, 8'd1);
    apply("R1", 2'b00, 8'd252, 8'd63, 8'd1);
    apply("R1", 2'b00, 8'd0,   8'd64, 8'd0);   // 256 would wrap to 0
    apply("R1", 2'b00, 8'd4,   8'd65, 8'd0);   // 260 would wrap to 4
    apply("R1", 2'b00, 8'd65,  8'd16, 8'd0);
    apply("R1", 2'b00, 8'd255, 8'd255, 8'd0);
  endtask

  task automatic t_mod16();
    apply("R2", 2'b01, 8'd16,  8'd3,   8'd1);
    apply("R2", 2'b01, 8'd0,   8'd255, 8'd1);
    apply("R2", 2'b01, 8'd255, 8'd0,   8'd0);
    apply("R2", 2'b01, 8'd24,  8'd16,  8'd0);
    for (int b = 0; b < 256; b += 17) begin
      apply("R2", 2'b01, 8'd240, 8'(b), 8'd1);  // opB ignored
      apply("R2", 2'b01, 8'd8,   8'(b), 8'd0);
    end
  endtask

  task automatic t_mul9();
    apply("R3", 2'b10, 8'd0,   8'd9,  8'd0);
    apply("R3", 2'b10, 8'd28,  8'd0,  8'd252);
    apply("R3", 2'b10, 8'd29,  8'd0,  8'd5);    // 261 mod 256
    apply("R3", 2'b10, 8'd255, 8'd77, 8'd247);  // 2295 mod 256
    for (int b = 0; b < 256; b += 51)
      apply("R3", 2'b10, 8'd16, 8'(b), 8'd144); // opB ignored
  endtask

  task automatic t_min();
    apply("R4", 2'b11, 8'd5,   8'd200, 8'd5);
    apply("R4", 2'b11, 8'd200, 8'd5,   8'd5);
    apply("R4", 2'b11, 8'd128, 8'd127, 8'd127); // unsigned, not signed
    apply("R4", 2'b11, 8'd77,  8'd77,  8'd77);
    apply("R4", 2'b11, 8'd255, 8'd255, 8'd255);
    apply("R4", 2'b11, 8'd0,   8'd255, 8'd0);
  endtask

  task automatic t_pred_word();
    // predicate results never set bits 7..1 (R5)
    for (int a = 0; a < 256; a += 5) begin
      apply("R5", 2'b00, 8'(a), 8'(a / 4), model(2'b00, 8'(a), 8'(a / 4)));
      apply("R5", 2'b01, 8'(a), 8'hFF,     model(2'b01, 8'(a), 8'hFF));
    end
  endtask

  task automatic t_no_state();
    // back-to-back opcode changes: each result depends only on present inputs (R6)
    apply("R6", 2'b10, 8'd255, 8'd0,  8'd247);
    apply("R6", 2'b11, 8'd3,   8'd9,  8'd3);
    apply("R6", 2'b00, 8'd36,  8'd9,  8'd1);
    apply("R6", 2'b10, 8'd1,   8'd9,  8'd9);
  endtask

  task automatic t_random();
    for (int k = 0; k < 2000; k++) begin
      logic [1:0] op = 2'($urandom);
      logic [7:0] a  = 8'($urandom);
      logic [7:0] b  = 8'($urandom);
      if (k % 4 == 0) a = 8'(int'(b) * 4);  // force quadruple hits
      apply("R1-R4 random", op, a, b, model(op, a, b));
    end
  endtask

  initial begin
    t_initial();
    t_quad();
    t_mod16();
    t_mul9();
    t_min();
    t_pred_word();
    t_no_state();
    t_random();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule